// File: doc/BRIEF.md
# Multi-Period Lock-In Demodulator

This block is a digital lock-in detector for one channel. Each clock it takes one signed sample and one sine/cosine reference pair. The reference comes from the channel's own oscillator or from an auxiliary oscillator. It multiplies the sample by both reference phases and keeps a running sum of each product. The sums cover a whole number of reference periods. That number is a power of two, from 1 to 32 periods, set by a 3-bit control.

When a block of periods closes, the block registers four results together and pulses a valid strobe for one cycle:
- the scaled in-phase (X) and quadrature (Y) sums;
- the squared magnitude X² + Y²;
- a coarse phase, given as an octant code. This phase can pass through a first-order low-pass filter.

The sample source is either the external converter stream or an internal loopback signal. The loopback signal is arithmetically shifted right before use. A high-resolution setting scales the results up by 64, with saturation at full scale. A debug output carries either the selected sine or the selected cosine.

Period boundaries are taken from the MSB of the selected oscillator's phase accumulator. The boundary is the cycle in which that MSB reads 0 after it read 1 in the cycle before. The sample of that cycle is the first sample of the new period.

Top module: `mp_lockin`

## Requirements
- R1: A boundary is a cycle where the selected MSB is 0 and the selected MSB of the previous cycle was 1. The block length is 2^n periods, with n = nWaves clamped to 5 (values 6 and 7 act as 5). A block closes at the boundary where the period count has reached or passed 2^n − 1. outValid is then high for exactly the cycle after that boundary edge. It is low otherwise.
- R2: xOut is built from the sum of sample × cosine and yOut from the sum of sample × sine. Each sum covers every sample from one closing boundary cycle (inclusive) to the next (exclusive). The boundary sample seeds the new sums. xOut and yOut change only together with outValid.
- R3: After reset, samples before the first boundary are discarded. That first boundary starts the first block and produces no outValid.
- R4: refSel = 1 selects auxMsb/auxSin/auxCos. refSel = 0 selects ownMsb/ownSin/ownCos. The selection applies to both the products and the boundary detection.
- R5: loopSel = 1 replaces adcIn with loopIn shifted arithmetically right by loopShift (0..15).
- R6: Each sum is shifted arithmetically right by 16 bits (hiRes = 0) or 10 bits (hiRes = 1). It is then saturated to the signed 16-bit range [−32768, 32767].
- R7: ampOut equals xOut² + yOut², registered together with xOut and yOut.
- R8: With filtEn = 0, phaseOut = k × 2^13, where k is the octant code:
  - x > 0, y ≥ 0: k is 0 if |y| < |x|, else 1.
  - x ≤ 0, y > 0: k is 2 if |x| < |y|, else 3.
  - x < 0, y ≤ 0: k is 4 if |y| < |x|, else 5.
  - x ≥ 0, y < 0: k is 6 if |x| < |y|, else 7.
  - x = y = 0: k is 0.
- R9: With filtEn = 1, at each outValid the phase state p becomes p + floor((raw − p) / 4), where raw is the R8 value and all values are treated as unsigned numbers.
- R10: dbgOut shows the selected cosine when dbgSel = 1 and the selected sine when dbgSel = 0, in the same cycle.
- R11: While rstN is low, xOut, yOut, ampOut, phaseOut and outValid are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| adcIn | input | 14 | Signed converter sample |
| loopIn | input | 14 | Signed internal loopback sample |
| loopSel | input | 1 | 1 selects the shifted loopback sample |
| loopShift | input | 4 | Right shift applied to loopIn |
| ownMsb | input | 1 | MSB of own oscillator phase |
| ownSin | input | 12 | Own oscillator sine, signed |
| ownCos | input | 12 | Own oscillator cosine, signed |
| auxMsb | input | 1 | MSB of auxiliary oscillator phase |
| auxSin | input | 12 | Auxiliary sine, signed |
| auxCos | input | 12 | Auxiliary cosine, signed |
| refSel | input | 1 | 1 selects the auxiliary reference |
| nWaves | input | 3 | Log2 of periods per block, clamped to 5 |
| hiRes | input | 1 | 64x output scaling |
| filtEn | input | 1 | Enables the phase low-pass filter |
| dbgSel | input | 1 | 1 routes cosine, 0 routes sine to dbgOut |
| xOut | output | 16 | In-phase result, signed |
| yOut | output | 16 | Quadrature result, signed |
| ampOut | output | 33 | Squared magnitude |
| phaseOut | output | 16 | Coarse (optionally filtered) phase |
| outValid | output | 1 | One-cycle result strobe |
| dbgOut | output | 12 | Selected sine or cosine |

## Verification
The bench goes after the boundary sample. If that sample were dropped or counted twice, X and Y would be off by one product in every block.

It also targets:
- nWaves above 5. A design that did not clamp it would never close a block.
- A shorter block length chosen mid-block. A design that compares the count for equality only would miss the close and run on for many periods.
- hiRes with large signals. A design that wrapped instead of saturating would flip the sign.
- Phase vectors lying on octant edges, where a wrong tie rule moves the code by one.
- The first partial period after reset. A design that did not discard it would produce an early, short result.

// File: rtl/mp_lockin_pkg.sv
package mp_lockin_pkg;

  // Strobes from the period control to the datapath
  typedef struct packed {
    logic load;   // seed sums with the current product
    logic add;    // add the current product to the sums
    logic latch;  // register the finished block results
  } ctrlStrobe_t;

endpackage

// File: rtl/mp_lockin_ctrl.sv
module mp_lockin_ctrl
  import mp_lockin_pkg::*;
#(
  parameter int N_MAX = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        refMsb,
  input  logic [2:0]  nWaves,
  output ctrlStrobe_t strobe
);

  localparam int CNT_W = (N_MAX < 1) ? 1 : N_MAX;

  logic             prevMsb;
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       nEff;
  logic [CNT_W-1:0] lastIdx;
  logic             periodEdge;
  logic             blockEnd;

  always_comb begin
    nEff    = (32'(nWaves) > N_MAX) ? 3'(N_MAX) : nWaves;
    lastIdx = CNT_W'((32'd1 << nEff) - 32'd1);
  end

  assign periodEdge = prevMsb & ~refMsb;
  assign blockEnd   = (cnt >= lastIdx);

  always_comb begin
    strobe.load  = periodEdge & (~armed | blockEnd);
    strobe.latch = periodEdge & armed & blockEnd;
    strobe.add   = armed & ~strobe.load;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevMsb <= 1'b0;
      armed   <= 1'b0;
      cnt     <= '0;
    end else begin
      prevMsb <= refMsb;
      if (periodEdge) begin
        armed <= 1'b1;
        cnt   <= strobe.load ? '0 : cnt + 1'b1;
      end
    end
  end

  AST_LATCH_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latch |-> armed); // R3

  AST_COUNT_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latch |=> (cnt == '0) && armed); // R1

endmodule

// File: rtl/mp_lockin_dp.sv
module mp_lockin_dp
  import mp_lockin_pkg::*;
#(
  parameter int DATA_W     = 14,
  parameter int REF_W      = 12,
  parameter int ACC_W      = 48,
  parameter int OUT_W      = 16,
  parameter int PH_W       = 16,
  parameter int SHIFT_NORM = 16,
  parameter int GAIN_BITS  = 6,
  parameter int FILT_K     = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic signed [DATA_W-1:0] sample,
  input  logic signed [REF_W-1:0]  refSin,
  input  logic signed [REF_W-1:0]  refCos,
  input  ctrlStrobe_t              strobe,
  input  logic                     hiRes,
  input  logic                     filtEn,
  output logic signed [OUT_W-1:0]  xOut,
  output logic signed [OUT_W-1:0]  yOut,
  output logic [2*OUT_W:0]         ampOut,
  output logic [PH_W-1:0]          phaseOut,
  output logic                     outValid
);

  localparam int PROD_W = DATA_W + REF_W;
  localparam int SH_HI  = SHIFT_NORM - GAIN_BITS;
  localparam logic signed [ACC_W-1:0] SAT_MAX =
    {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SAT_MIN =
    {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [PROD_W-1:0] prodX, prodY;
  logic signed [ACC_W-1:0]  extX, extY;
  logic signed [ACC_W-1:0]  accX, accY;
  logic signed [OUT_W-1:0]  xNext, yNext;
  logic signed [2*OUT_W-1:0] sqX, sqY;
  logic [2*OUT_W:0]         ampNext;
  logic [2:0]               octNext;
  logic [PH_W-1:0]          phRaw, phNext;

  assign prodX = sample * refCos;
  assign prodY = sample * refSin;
  assign extX  = {{(ACC_W-PROD_W){prodX[PROD_W-1]}}, prodX};
  assign extY  = {{(ACC_W-PROD_W){prodY[PROD_W-1]}}, prodY};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accX <= '0;
      accY <= '0;
    end else if (strobe.load) begin
      accX <= extX;
      accY <= extY;
    end else if (strobe.add) begin
      accX <= accX + extX;
      accY <= accY + extY;
    end
  end

  function automatic logic signed [OUT_W-1:0] satScale(
    input logic signed [ACC_W-1:0] a, input logic hr);
    logic signed [ACC_W-1:0] s;
    s = hr ? (a >>> SH_HI) : (a >>> SHIFT_NORM);
    if (s > SAT_MAX)      return SAT_MAX[OUT_W-1:0];
    else if (s < SAT_MIN) return SAT_MIN[OUT_W-1:0];
    else                  return s[OUT_W-1:0];
  endfunction

  function automatic logic [2:0] octantOf(
    input logic signed [OUT_W-1:0] x, input logic signed [OUT_W-1:0] y);
    logic signed [OUT_W:0] xe, ye;
    logic [OUT_W:0] ax, ay;
    logic xPos, xNeg, yPos, yNeg;
    xe = {x[OUT_W-1], x};
    ye = {y[OUT_W-1], y};
    ax = xe[OUT_W] ? (~xe + 1'b1) : xe;
    ay = ye[OUT_W] ? (~ye + 1'b1) : ye;
    xNeg = x[OUT_W-1];
    yNeg = y[OUT_W-1];
    xPos = !xNeg && (x != '0);
    yPos = !yNeg && (y != '0);
    if (xPos && !yNeg)      return (ay < ax) ? 3'd0 : 3'd1;
    else if (!xPos && yPos) return (ax < ay) ? 3'd2 : 3'd3;
    else if (xNeg && !yPos) return (ay < ax) ? 3'd4 : 3'd5;
    else if (!xNeg && yNeg) return (ax < ay) ? 3'd6 : 3'd7;
    else                    return 3'd0;
  endfunction

  always_comb begin
    xNext   = satScale(accX, hiRes);
    yNext   = satScale(accY, hiRes);
    sqX     = xNext * xNext;
    sqY     = yNext * yNext;
    ampNext = {1'b0, sqX} + {1'b0, sqY};
    octNext = octantOf(xNext, yNext);
    phRaw   = {octNext, {(PH_W-3){1'b0}}};
  end

  generate
    if (FILT_K > 0) begin : g_phaseFilt
      logic signed [PH_W:0] diff, step;
      logic [PH_W:0]        sum;
      always_comb begin
        diff = $signed({1'b0, phRaw}) - $signed({1'b0, phaseOut});
        step = diff >>> FILT_K;
        sum  = {1'b0, phaseOut} + step;
        phNext = filtEn ? sum[PH_W-1:0] : phRaw;
      end
    end else begin : g_phaseDirect
      assign phNext = phRaw;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xOut     <= '0;
      yOut     <= '0;
      ampOut   <= '0;
      phaseOut <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strobe.latch;
      if (strobe.latch) begin
        xOut     <= xNext;
        yOut     <= yNext;
        ampOut   <= ampNext;
        phaseOut <= phNext;
      end
    end
  end

  logic signed [2*OUT_W-1:0] chkSqX, chkSqY;
  assign chkSqX = xOut * xOut;
  assign chkSqY = yOut * yOut;

  AST_AMP_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ampOut == ({1'b0, chkSqX} + {1'b0, chkSqY})); // R7

  AST_HOLD_XY: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(xOut) && $stable(yOut)); // R2

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid); // R1

endmodule

// File: rtl/mp_lockin.sv
module mp_lockin
  import mp_lockin_pkg::*;
#(
  parameter int DATA_W     = 14,
  parameter int REF_W      = 12,
  parameter int ACC_W      = 48,
  parameter int OUT_W      = 16,
  parameter int PH_W       = 16,
  parameter int SHIFT_NORM = 16,
  parameter int GAIN_BITS  = 6,
  parameter int FILT_K     = 2,
  parameter int N_MAX      = 5,
  parameter int LSH_W      = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic signed [DATA_W-1:0] adcIn,
  input  logic signed [DATA_W-1:0] loopIn,
  input  logic                     loopSel,
  input  logic [LSH_W-1:0]         loopShift,
  input  logic                     ownMsb,
  input  logic signed [REF_W-1:0]  ownSin,
  input  logic signed [REF_W-1:0]  ownCos,
  input  logic                     auxMsb,
  input  logic signed [REF_W-1:0]  auxSin,
  input  logic signed [REF_W-1:0]  auxCos,
  input  logic                     refSel,
  input  logic [2:0]               nWaves,
  input  logic                     hiRes,
  input  logic                     filtEn,
  input  logic                     dbgSel,
  output logic signed [OUT_W-1:0]  xOut,
  output logic signed [OUT_W-1:0]  yOut,
  output logic [2*OUT_W:0]         ampOut,
  output logic [PH_W-1:0]          phaseOut,
  output logic                     outValid,
  output logic signed [REF_W-1:0]  dbgOut
);

  logic signed [DATA_W-1:0] sampleSel;
  logic signed [REF_W-1:0]  refSin, refCos;
  logic                     refMsb;
  ctrlStrobe_t              strobe;

  always_comb begin
    sampleSel = loopSel ? (loopIn >>> loopShift) : adcIn;
    refMsb    = refSel ? auxMsb : ownMsb;
    refSin    = refSel ? auxSin : ownSin;
    refCos    = refSel ? auxCos : ownCos;
    dbgOut    = dbgSel ? refCos : refSin;
  end

  mp_lockin_ctrl #(.N_MAX(N_MAX)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .refMsb (refMsb),
    .nWaves (nWaves),
    .strobe (strobe)
  );

  mp_lockin_dp #(
    .DATA_W(DATA_W), .REF_W(REF_W), .ACC_W(ACC_W), .OUT_W(OUT_W),
    .PH_W(PH_W), .SHIFT_NORM(SHIFT_NORM), .GAIN_BITS(GAIN_BITS),
    .FILT_K(FILT_K)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sample   (sampleSel),
    .refSin   (refSin),
    .refCos   (refCos),
    .strobe   (strobe),
    .hiRes    (hiRes),
    .filtEn   (filtEn),
    .xOut     (xOut),
    .yOut     (yOut),
    .ampOut   (ampOut),
    .phaseOut (phaseOut),
    .outValid (outValid)
  );

endmodule

// File: tb/mp_lockin_tb.sv
module mp_lockin_tb;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic               rstN;
  logic signed [13:0] adcIn, loopIn;
  logic               loopSel;
  logic [3:0]         loopShift;
  logic               ownMsb, auxMsb;
  logic signed [11:0] ownSin, ownCos, auxSin, auxCos;
  logic               refSel;
  logic [2:0]         nWaves;
  logic               hiRes, filtEn, dbgSel;
  logic signed [15:0] xOut, yOut;
  logic [32:0]        ampOut;
  logic [15:0]        phaseOut;
  logic               outValid;
  logic signed [11:0] dbgOut;

  mp_lockin u_dut (
    .clk(clk), .rstN(rstN), .adcIn(adcIn), .loopIn(loopIn), .loopSel(loopSel),
    .loopShift(loopShift), .ownMsb(ownMsb), .ownSin(ownSin), .ownCos(ownCos),
    .auxMsb(auxMsb), .auxSin(auxSin), .auxCos(auxCos), .refSel(refSel),
    .nWaves(nWaves), .hiRes(hiRes), .filtEn(filtEn), .dbgSel(dbgSel),
    .xOut(xOut), .yOut(yOut), .ampOut(ampOut), .phaseOut(phaseOut),
    .outValid(outValid), .dbgOut(dbgOut)
  );

  int    checks = 0;
  int    failures = 0;
  bit    finished = 0;
  string tag = "R2";

  bit [31:0] ownPh, auxPh, ownInc, auxInc;
  real       sigAmp, sigPhi, loopAmp;
  bit        sigFromAux;

  longint mAccX, mAccY, eAmp;
  int     mCnt, eX, eY, ePh, eDbg, validSeen;
  bit     mArmed, mPrev, eValid;

  function automatic int waveVal(bit [31:0] ph, real amp, real phi, bit useCos, int lim);
    real a, v;
    int  r;
    a = 6.283185307179586 * (real'(ph) / 4294967296.0) + phi;
    v = useCos ? $cos(a) : $sin(a);
    r = $rtoi($floor(amp * v + 0.5));
    if (r > lim) r = lim;
    if (r < -lim - 1) r = -lim - 1;
    return r;
  endfunction

  function automatic int satOut(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int octant(int x, int y);
    int ax, ay;
    ax = (x < 0) ? -x : x;
    ay = (y < 0) ? -y : y;
    if (x > 0 && y >= 0)  return (ay < ax) ? 0 : 1;
    if (x <= 0 && y > 0)  return (ax < ay) ? 2 : 3;
    if (x < 0 && y <= 0)  return (ay < ax) ? 4 : 5;
    if (x >= 0 && y < 0)  return (ax < ay) ? 6 : 7;
    return 0;
  endfunction

  task automatic modelReset();
    mAccX = 0; mAccY = 0; mCnt = 0; mArmed = 0; mPrev = 0;
    eX = 0; eY = 0; eAmp = 0; ePh = 0; eValid = 0;
  endtask

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    int  aVal, lVal, samp, sSin, sCos, nE, last, raw, sh;
    bit  sMsb, edgeSeen, doLoad, doLatch;
    longint pX, pY;
    ownPh += ownInc;
    auxPh += auxInc;
    ownMsb = ownPh[31];
    auxMsb = auxPh[31];
    ownSin = 12'(waveVal(ownPh, 2047.0, 0.0, 0, 2047));
    ownCos = 12'(waveVal(ownPh, 2047.0, 0.0, 1, 2047));
    auxSin = 12'(waveVal(auxPh, 2047.0, 0.0, 0, 2047));
    auxCos = 12'(waveVal(auxPh, 2047.0, 0.0, 1, 2047));
    aVal = waveVal(sigFromAux ? auxPh : ownPh, sigAmp, sigPhi, 1, 8191)
           + $urandom_range(0, 6) - 3;
    if (aVal > 8191) aVal = 8191;
    if (aVal < -8192) aVal = -8192;
    lVal = waveVal(sigFromAux ? auxPh : ownPh, loopAmp, sigPhi, 1, 8191);
    adcIn  = 14'(aVal);
    loopIn = 14'(lVal);

    // reference model of the next clock edge
    sMsb = refSel ? auxMsb : ownMsb;
    sSin = refSel ? int'(auxSin) : int'(ownSin);
    sCos = refSel ? int'(auxCos) : int'(ownCos);
    eDbg = dbgSel ? sCos : sSin;
    samp = loopSel ? (lVal >>> loopShift) : aVal;
    pX = longint'(samp) * sCos;
    pY = longint'(samp) * sSin;
    edgeSeen = mPrev && !sMsb;
    nE = (nWaves > 5) ? 5 : int'(nWaves);
    last = (1 << nE) - 1;
    doLoad  = edgeSeen && (!mArmed || mCnt >= last);
    doLatch = edgeSeen && mArmed && mCnt >= last;
    eValid = doLatch;
    if (doLatch) begin
      sh = hiRes ? 10 : 16;
      eX = satOut(mAccX >>> sh);
      eY = satOut(mAccY >>> sh);
      eAmp = longint'(eX) * eX + longint'(eY) * eY;
      raw = octant(eX, eY) * 8192;
      if (filtEn) ePh = ePh + ((raw - ePh) >>> 2);
      else        ePh = raw;
    end
    if (doLoad) begin
      mAccX = pX; mAccY = pY;
    end else if (mArmed) begin
      mAccX += pX; mAccY += pY;
    end
    if (edgeSeen) begin
      mArmed = 1;
      mCnt = doLoad ? 0 : mCnt + 1;
    end
    mPrev = sMsb;

    @(posedge clk);
    #2;
    check(outValid == eValid, "R1", "valid", outValid, eValid);
    check(int'(xOut) == eX && int'(yOut) == eY, tag, "x/y",
          longint'(xOut) * 65536 + yOut, longint'(eX) * 65536 + eY);
    check(longint'(ampOut) == eAmp, "R7", "amp", ampOut, eAmp);
    check(int'(phaseOut) == ePh, filtEn ? "R9" : "R8", "phase", phaseOut, ePh);
    check(int'(dbgOut) == eDbg, "R10", "dbg", dbgOut, eDbg);
    if (outValid) validSeen++;
    @(negedge clk);
  endtask

  task automatic runFor(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic doReset();
    rstN = 1'b0;
    modelReset();
    @(posedge clk);
    #2;
    check(xOut == 0 && yOut == 0 && ampOut == 0 && phaseOut == 0 && !outValid,
          "R11", "reset outputs", longint'(ampOut) + phaseOut, 0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic scene(string t, int n);
    tag = t;
    validSeen = 0;
    runFor(n);
    check(validSeen > 0, "R1", "blocks seen", validSeen, 1);
  endtask

  initial begin
    rstN = 1'b0; adcIn = '0; loopIn = '0; loopSel = 0; loopShift = 0;
    ownMsb = 0; auxMsb = 0; ownSin = '0; ownCos = '0; auxSin = '0; auxCos = '0;
    refSel = 0; nWaves = 0; hiRes = 0; filtEn = 0; dbgSel = 0;
    ownPh = 0; auxPh = 0; ownInc = 32'h1000_0000; auxInc = 32'd214748364;
    sigAmp = 6000.0; sigPhi = 0.0; loopAmp = 8000.0; sigFromAux = 0;
    @(negedge clk);
    doReset();

    // R3: first partial period is discarded, one period per block
    scene("R3", 120);
    // several phases give distinct octants
    nWaves = 2;
    for (int k = 0; k < 8; k++) begin
      sigPhi = 0.785398 * k + 0.3;
      scene("R2", 160);
    end
    sigPhi = 0.0;
    dbgSel = 1;
    scene("R2", 140);
    // R6: high resolution saturates on a large signal, not on a small one
    hiRes = 1; nWaves = 0;
    scene("R6", 100);
    sigAmp = 30.0;
    scene("R6", 100);
    sigAmp = 6000.0; hiRes = 0;
    // R1: clamp of nWaves above 5
    nWaves = 7;
    scene("R1", 1100);
    // R1: shorter block selected mid-block
    nWaves = 5;
    runFor(100);
    nWaves = 1;
    scene("R1", 200);
    // R4: auxiliary reference
    refSel = 1; sigFromAux = 1; dbgSel = 0;
    scene("R4", 300);
    dbgSel = 1;
    scene("R4", 100);
    // R5: loopback with shifts
    refSel = 0; sigFromAux = 0; loopSel = 1;
    for (int s = 0; s < 16; s += 5) begin
      loopShift = 4'(s);
      scene("R5", 120);
    end
    loopSel = 0;
    // R9: phase filter over changing phases
    filtEn = 1; nWaves = 0;
    for (int k = 0; k < 6; k++) begin
      sigPhi = 1.3 * k;
      scene("R9", 50);
    end
    filtEn = 0;
    // R3 again after a mid-run reset
    doReset();
    scene("R3", 80);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule